// File: doc/BRIEF.md
# Grid Phase Histogram Classifier

This block decides which of three supply phases a remote node shares with a reference node. An upstream matcher slides a window over a reference trace and, for each window, reports a signed alignment error: the difference between the position where the best match was found and the position where it was expected. Each error arrives tagged with the candidate phase it was computed against. When the two nodes share a phase, nearly all errors for that phase fall into one value. A wrong phase scatters its errors over many values.

For each phase, the block keeps a histogram of the errors in block-RAM-style counter banks. A session opens with a start pulse, which wipes every bin. Errors are then streamed in, one per cycle. An end pulse closes the session. The block then reads all bins in order, finds the tallest bin of each phase, and reports the winning phase and its bin height. The result stays valid until the next session opens. A typical session carries on the order of a thousand errors per phase.

Top module: `phase_hist_classifier`

## Requirements
- R1: During and after reset, and before any result, `res_valid`, `res_phase` and `res_peak` are all 0.
- R2: With BIN_W=10, an error is binned only when it lies in −512..+511. Both −512 and +511 are counted. Errors such as +512 or −513 are discarded and do not land in any bin.
- R3: A sample tagged with phase code 3 is discarded. Codes 0, 1 and 2 name the three phases.
- R4: A start pulse clears all bins of all three phases, so a result never includes counts from an earlier session.
- R5: Samples are counted only while collecting. Collecting begins 2^BIN_W + 1 cycles after the cycle in which the start pulse is sampled, once the bins are clear. Samples presented earlier than that are ignored, and so are samples presented after the end pulse.
- R6: Samples arrive at one per cycle, with no gaps needed. Back-to-back samples into the same bin of the same phase, or into the same bin of different phases, are all counted.
- R7: The reported phase is the one whose histogram holds the tallest single bin.
- R8: When two or more phases share the tallest bin height, the lowest-numbered of them is reported. A session with no counted samples reports phase 0 with peak 0.
- R9: Bin counters saturate at 2^CNT_W − 1 (1023 by default) and never wrap.
- R10: `res_valid` rises exactly 2^BIN_W + 3 clock edges after the edge that samples the end pulse. It then holds, with `res_phase` and `res_peak` stable, until a start pulse, which clears it on the edge that samples the start.
- R11: A start pulse during a session discards that session and begins a new one.
- R12: `res_peak` equals the height of the tallest bin of the reported phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_start | input | 1 | One-cycle pulse: clear bins and open a session |
| sess_end | input | 1 | One-cycle pulse: close the session and start classification |
| err_vld | input | 1 | Alignment-error sample present |
| err_phase | input | 2 | Phase tag of the sample (0..2; 3 is discarded) |
| err_val | input | IN_W (16) | Signed alignment error |
| res_phase | output | 2 | Chosen phase |
| res_peak | output | CNT_W (10) | Tallest bin height of the chosen phase |
| res_valid | output | 1 | Result valid, held until the next start |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Read-modify-write hazard.** Bursts of identical errors are sent back-to-back, and two phases are interleaved into the same bin on alternate cycles. A design without forwarding would undercount these bursts and report a lower peak.
- **Range edges.** Errors are placed just inside and just outside the binned range. A range check off by one would drop −512, or would fold +512 and −513 into an end bin and inflate its peak.
- **Tie-break.** Tied peaks are used, as is an empty session. A wrong tie-break would report phase 1 or 2.
- **Saturation.** A run long enough to saturate a counter is sent. A wrapping counter would report a small peak or lose the phase.
- **Ignored samples.** Samples are sent during the clear sweep and after the end pulse, and one session is restarted halfway. Any of these leaking into the bins would change the winning phase.

// File: rtl/phx_pkg.sv
package phx_pkg;
  localparam int NUM_PH = 3;
  localparam int PH_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COLLECT,
    ST_DRAIN,
    ST_SCAN,
    ST_RESOLVE,
    ST_PICK
  } phx_state_t;
endpackage

// File: rtl/phx_binner.sv
// Range check and bin index for one signed alignment error.
module phx_binner #(
  parameter int IN_W  = 16,
  parameter int BIN_W = 10
) (
  input  logic [IN_W-1:0]  err,
  output logic             in_range,
  output logic [BIN_W-1:0] bin
);
  // Offset-binary index: flipping the sign bit maps -2^(BIN_W-1) to bin 0.
  assign bin = {~err[BIN_W-1], err[BIN_W-2:0]};

  generate
    if (IN_W > BIN_W) begin : g_wide
      // In range when every bit above the bin field repeats its sign bit.
      localparam int TOP_W = IN_W - BIN_W + 1;
      logic [TOP_W-1:0] top;
      assign top      = err[IN_W-1:BIN_W-1];
      assign in_range = (top == '0) || (top == '1);
    end else begin : g_exact
      assign in_range = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/phx_bank.sv
// One phase's histogram: a simple dual-port RAM with a registered read.
module phx_bank #(
  parameter int BIN_W = 10,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [BIN_W-1:0] waddr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [BIN_W-1:0] raddr,
  output logic [CNT_W-1:0] rdata
);
  localparam int DEPTH = 1 << BIN_W;

  logic [CNT_W-1:0] mem [DEPTH];

  // A read in the same cycle as a write to that address returns the old word.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/phx_peak.sv
// Per-phase running maximum over the scan, plus the winner pick.
module phx_peak
  import phx_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         en,
  input  logic [NUM_PH-1:0][CNT_W-1:0] cnt,
  output logic [NUM_PH-1:0][CNT_W-1:0] pk,
  output logic [PH_W-1:0]              best_ph,
  output logic [CNT_W-1:0]             best_pk
);
  genvar p;
  generate
    for (p = 0; p < NUM_PH; p++) begin : g_ph
      always_ff @(posedge clk) begin
        if (rst || clr)                  pk[p] <= '0;
        else if (en && (cnt[p] > pk[p])) pk[p] <= cnt[p];
      end
    end
  endgenerate

  // Ascending scan and a strict compare: on a tie the lower phase keeps the win.
  always_comb begin
    best_ph = '0;
    best_pk = pk[0];
    for (int i = 1; i < NUM_PH; i++) begin
      if (pk[i] > best_pk) begin
        best_ph = PH_W'(i);
        best_pk = pk[i];
      end
    end
  end
endmodule

// File: rtl/phase_hist_classifier.sv
module phase_hist_classifier
  import phx_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int BIN_W = 10,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sess_start,
  input  logic             sess_end,
  input  logic             err_vld,
  input  logic [1:0]       err_phase,
  input  logic [IN_W-1:0]  err_val,
  output logic [1:0]       res_phase,
  output logic [CNT_W-1:0] res_peak,
  output logic             res_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phx_state_t state;
  logic [BIN_W-1:0] clr_addr;
  logic [BIN_W-1:0] scan_addr;
  logic             clr_active;

  // Input decode
  logic             in_range;
  logic [BIN_W-1:0] in_bin;
  logic             accept;

  phx_binner #(.IN_W(IN_W), .BIN_W(BIN_W)) u_binner (
    .err      (err_val),
    .in_range (in_range),
    .bin      (in_bin)
  );

  assign clr_active = (state == ST_CLEAR);
  assign accept = err_vld && in_range && (err_phase < PH_W'(NUM_PH)) &&
                  (state == ST_COLLECT) && !sess_start;

  // Update pipeline: the bank read is issued with the sample, and the write lands one cycle later.
  logic             s1_vld;
  logic [PH_W-1:0]  s1_ph;
  logic [BIN_W-1:0] s1_bin;

  logic             lw_vld;
  logic [PH_W-1:0]  lw_ph;
  logic [BIN_W-1:0] lw_bin;
  logic [CNT_W-1:0] lw_val;

  logic [NUM_PH-1:0][CNT_W-1:0] rd_q;
  logic [CNT_W-1:0]             base;
  logic                         fwd;
  logic                         upd_we;
  logic [CNT_W-1:0]             upd_data;
  logic [BIN_W-1:0]             rd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_ph  <= '0;
      s1_bin <= '0;
    end else begin
      s1_vld <= accept;
      s1_ph  <= err_phase;
      s1_bin <= in_bin;
    end
  end

  // Forward the word written last cycle: the bank read did not see it.
  assign fwd = lw_vld && (lw_ph == s1_ph) && (lw_bin == s1_bin);

  always_comb begin
    base = '0;
    for (int i = 0; i < NUM_PH; i++) begin
      if (s1_ph == PH_W'(i)) base = rd_q[i];
    end
    if (fwd) base = lw_val;
  end

  assign upd_we   = s1_vld;
  assign upd_data = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_vld <= 1'b0;
      lw_ph  <= '0;
      lw_bin <= '0;
      lw_val <= '0;
    end else begin
      lw_vld <= upd_we && !clr_active;
      lw_ph  <= s1_ph;
      lw_bin <= s1_bin;
      lw_val <= upd_data;
    end
  end

  assign rd_addr = (state == ST_SCAN) ? scan_addr : in_bin;

  // Histogram banks, one per phase
  genvar p;
  generate
    for (p = 0; p < NUM_PH; p++) begin : g_bank
      logic             we;
      logic [BIN_W-1:0] waddr;
      logic [CNT_W-1:0] wdata;

      assign we    = clr_active || (upd_we && (s1_ph == PH_W'(p)));
      assign waddr = clr_active ? clr_addr : s1_bin;
      assign wdata = clr_active ? '0 : upd_data;

      phx_bank #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_bank (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (rd_q[p])
      );
    end
  endgenerate

  // Peak search
  logic                         rd_vld;
  logic [NUM_PH-1:0][CNT_W-1:0] phase_peak;
  logic [PH_W-1:0]              best_ph;
  logic [CNT_W-1:0]             best_pk;

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= (state == ST_SCAN);
  end

  phx_peak #(.CNT_W(CNT_W)) u_peak (
    .clk     (clk),
    .rst     (rst),
    .clr     (state == ST_DRAIN),
    .en      (rd_vld),
    .cnt     (rd_q),
    .pk      (phase_peak),
    .best_ph (best_ph),
    .best_pk (best_pk)
  );

  // Session control
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      clr_addr  <= '0;
      scan_addr <= '0;
      res_phase <= '0;
      res_peak  <= '0;
      res_valid <= 1'b0;
    end else if (sess_start) begin
      state     <= ST_CLEAR;
      clr_addr  <= '0;
      res_valid <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_CLEAR: begin
          clr_addr <= clr_addr + 1'b1;
          if (clr_addr == '1) state <= ST_COLLECT;
        end
        ST_COLLECT: if (sess_end) state <= ST_DRAIN;
        ST_DRAIN: begin
          scan_addr <= '0;
          state     <= ST_SCAN;
        end
        ST_SCAN: begin
          scan_addr <= scan_addr + 1'b1;
          if (scan_addr == '1) state <= ST_RESOLVE;
        end
        ST_RESOLVE: state <= ST_PICK;
        ST_PICK: begin
          res_phase <= best_ph;
          res_peak  <= best_pk;
          res_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_hist_classifier_chk.sv
module phase_hist_classifier_chk #(
  parameter int CNT_W  = 10,
  parameter int NUM_PH = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         sess_start,
  input logic                         res_valid,
  input logic [1:0]                   res_phase,
  input logic [CNT_W-1:0]             res_peak,
  input logic                         upd_we,
  input logic [CNT_W-1:0]             upd_data,
  input logic [NUM_PH-1:0][CNT_W-1:0] phase_peak
);
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    upd_we |-> (upd_data != '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !sess_start) |=> (res_valid && $stable(res_phase) && $stable(res_peak)));

  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    sess_start |=> !res_valid);

  a_r7_legal_phase: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_phase < 2'd3));

  a_r8_tie_low: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> ((res_phase == 2'd0) || (phase_peak[0] < res_peak)));

  a_r12_peak_match: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> (phase_peak[res_phase] == res_peak));
endmodule

bind phase_hist_classifier phase_hist_classifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sess_start (sess_start),
  .res_valid  (res_valid),
  .res_phase  (res_phase),
  .res_peak   (res_peak),
  .upd_we     (upd_we),
  .upd_data   (upd_data),
  .phase_peak (phase_peak)
);

// File: tb/phase_hist_classifier_tb.sv
`timescale 1ns/1ps
module phase_hist_classifier_tb;
  localparam int IN_W  = 16;
  localparam int BIN_W = 10;
  localparam int CNT_W = 10;
  localparam int NB    = 1 << BIN_W;
  localparam int HALF  = NB / 2;
  localparam int SAT   = (1 << CNT_W) - 1;
  localparam int LAT   = NB + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sess_start = 1'b0;
  logic sess_end = 1'b0;
  logic err_vld = 1'b0;
  logic [1:0] err_phase = '0;
  logic [IN_W-1:0] err_val = '0;
  logic [1:0] res_phase;
  logic [CNT_W-1:0] res_peak;
  logic res_valid;

  always #2.5 clk = ~clk;

  phase_hist_classifier #(.IN_W(IN_W), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .sess_start(sess_start), .sess_end(sess_end),
    .err_vld(err_vld), .err_phase(err_phase), .err_val(err_val),
    .res_phase(res_phase), .res_peak(res_peak), .res_valid(res_valid)
  );

  typedef struct {
    int     ph;
    int     pk;
    longint due;
  } exp_t;

  exp_t   expq[$];
  exp_t   last_exp;
  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  bit     done   = 1'b0;
  bit     collecting = 1'b0;
  int     hist [3][NB];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard monitor: a result's phase, peak and arrival cycle (R7, R8, R10, R12).
  bit prev_v = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid && !prev_v) begin
        if (expq.size() == 0) begin
          check("R10 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check("R7 R8 phase", res_phase, e.ph);
          check("R9 R12 peak", res_peak, e.pk);
          check("R10 latency", cyc, e.due);
        end
      end
      prev_v <= res_valid;
    end
  end

  // Driver tasks: each starts just after a falling edge and ends on one.
  task automatic send(int ph, int err);
    err_vld   = 1'b1;
    err_phase = ph[1:0];
    err_val   = IN_W'(err);
    if (collecting && ph < 3 && err >= -HALF && err < HALF)
      hist[ph][err + HALF] = (hist[ph][err + HALF] < SAT) ? hist[ph][err + HALF] + 1 : SAT;
    @(negedge clk);
    err_vld = 1'b0;
  endtask

  task automatic open_session(int junk);
    sess_start = 1'b1;
    collecting = 1'b0;
    foreach (hist[i, j]) hist[i][j] = 0;
    @(negedge clk);
    sess_start = 1'b0;
    check("R10 start clears valid", res_valid, 0);
    // R5: samples inside the clear sweep must be ignored.
    for (int i = 0; i < NB; i++) begin
      if (i < junk) send(2, 3);
      else @(negedge clk);
    end
    collecting = 1'b1;
  endtask

  task automatic close_session(int junk);
    exp_t e;
    e.ph = 0;
    e.pk = 0;
    for (int p = 0; p < 3; p++)
      for (int b = 0; b < NB; b++)
        if (hist[p][b] > e.pk) begin
          e.pk = hist[p][b];
          e.ph = p;
        end
    e.due = cyc + 1 + LAT;
    expq.push_back(e);
    last_exp   = e;
    collecting = 1'b0;
    sess_end   = 1'b1;
    @(negedge clk);
    sess_end = 1'b0;
    // R5: samples after the end pulse must be ignored.
    for (int i = 0; i < junk; i++) send(1, 5);
    while (expq.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R10 valid held", res_valid, 1);
    check("R10 phase held", res_phase, last_exp.ph);
    check("R10 peak held", res_peak, last_exp.pk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset valid", res_valid, 0);
    check("R1 reset phase", res_phase, 0);
    check("R1 reset peak", res_peak, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle valid", res_valid, 0);

    // S1 (R5, R6, R7): junk during the clear; phase 1 concentrated, the others dispersed. Expect phase 1, peak 40.
    open_session(60);
    for (int i = 0; i < 40; i++) send(1, 5);
    for (int i = -20; i < 20; i++) send(0, i);
    for (int i = 100; i < 140; i++) send(2, i);
    close_session(0);

    // S2 (R6, R8): phases 0 and 2 interleaved into the same bin; tie at 30 goes to phase 0.
    open_session(0);
    for (int i = 0; i < 30; i++) begin
      send(0, -3);
      send(2, -3);
      send(1, i);
    end
    close_session(0);

    // S3 (R2, R3): edges of the range. Phase 0 peak 12 wins over phase 2 at 11.
    open_session(0);
    for (int i = 0; i < 50; i++) send(0, 512);
    for (int i = 0; i < 50; i++) send(0, -513);
    for (int i = 0; i < 12; i++) send(0, -512);
    for (int i = 0; i < 12; i++) send(0, 511);
    for (int i = 0; i < 11; i++) send(2, 0);
    for (int i = 0; i < 100; i++) send(3, 0);
    close_session(0);

    // S4 (R4, R5): fresh bins; phase 1 samples after the end pulse are ignored. Expect phase 2, peak 8.
    open_session(0);
    for (int i = 0; i < 8; i++) send(2, 5);
    close_session(100);

    // S5 (R8): empty session reports phase 0, peak 0.
    open_session(0);
    close_session(0);

    // S6 (R9): saturation at 1023.
    open_session(0);
    for (int i = 0; i < 1100; i++) send(1, -7);
    close_session(0);

    // S7 (R11): restart in the middle of a session; then a phase 1 / phase 2 tie at 6 goes to phase 1.
    open_session(0);
    for (int i = 0; i < 50; i++) send(0, 1);
    open_session(0);
    for (int i = 0; i < 6; i++) begin
      send(2, 1);
      send(1, 2);
    end
    close_session(0);

    report();
  end
endmodule